// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synthesizable model of a 2 Kbit nonvolatile memory that answers on a three-wire serial bus. The bus master drives a select, a serial clock and a data input. The block returns read data and programming status on a data output that can be released to high impedance. All bus inputs pass through a synchronizer into the system clock domain, and the block detects edges there. Bit sampling follows the rising edges of the serial clock. Programming is launched by the falling edge of the select, after a complete instruction has been shifted in.

A strap input chooses the word size. With the strap high the array is 128 words of 16 bits. With it low the array is 256 bytes. Seven commands are decoded: read, write, erase, erase-all, write-all, enable and disable. The array holds its updates back until a self-timed busy period has run out. That period is counted in system clocks and is set by parameters, one length for single-word operations and a longer one for write-all.

Top module: `uw_eeprom`

## Requirements
- R1: A start is the first serial-clock rising edge with select and data-in both high. Any number of rising edges with data-in low before it leave the block idle.
- R2: After the start, two opcode bits are taken: 10 read, 01 write, 11 erase. Opcode 00 takes the next two bits as a sub-code: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: With org16_i high, the address field is 8 bits, a don't-care bit followed by a 7-bit word address, and data is 16 bits. With org16_i low, the address field is 9 bits, a don't-care bit followed by an 8-bit byte address, and data is 8 bits. All fields are sent MSB first.
- R4: An instruction is executed only if every required bit arrived before select fell: 11/12 clocks for address-only commands and 27/20 for commands carrying data (16-bit/8-bit). A truncated instruction changes nothing.
- R5: A read drives do_o to 0 with do_oe_o high after the last address bit. The word then follows, MSB first, one bit per serial rising edge. While select stays high the address increments and wraps, and the following words stream out with no further dummy bit.
- R6: After reset, writes, erases, erase-all and write-all are ignored until an enable command is executed. A disable command locks them again. Read works in either state.
- R7: Erase sets the addressed word to all ones. Erase-all sets every word to all ones. Write-all sets every word to the given data.
- R8: With select low, do_oe_o is low. After a programming launch, raising select drives the status on do_o: 0 while busy, 1 when ready. A start bit followed by select low removes the status, so do_oe_o stays low on the next select high.
- R9: A programming cycle lasts BUSY_CYC system clocks (WRAL_CYC for write-all) and completes whatever select does. A start bit received while busy is not executed.
- R10: After reset, do_oe_o is low and every word of the array reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| org16_i | input | 1 | Word size strap: 1 = 16-bit, 0 = 8-bit |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out (read data or status) |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
Each serial input passes through two synchronizer flops. Output registers update in the third system clock after the bench changes a serial input. The bench keeps every serial clock phase at six system clocks and samples do_o and do_oe_o at the end of the low phase that follows each rising edge, three cycles after the update is due. Status is sampled six cycles after select rises. Busy-to-ready is found by polling with a bound, and array contents are checked only after the busy period has ended.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL, OP_EWEN, OP_EWDS
  } uw_op_e;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= '0;
    else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/uw_array.sv
module uw_array
  import uw_pkg::*;
#(
  parameter int BYTES    = 256,
  parameter int BYTE_W   = 8,
  parameter int BUSY_CYC = 200,
  parameter int WRAL_CYC = 600,
  localparam int AW = $clog2(BYTES),
  localparam int DW = 2 * BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          org16_i,
  input  logic          launch_i,
  input  uw_op_e        op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_word_o,
  output logic          busy_o
);
  localparam int CW = $clog2(WRAL_CYC + 1);

  logic [BYTE_W-1:0] mem [BYTES];
  logic [CW-1:0]     cnt;
  uw_op_e            p_op;
  logic [AW-1:0]     p_addr;
  logic [DW-1:0]     p_data;
  logic              p_org;
  logic              commit;

  assign busy_o = (cnt != '0);
  assign commit = (cnt == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      p_op   <= OP_NONE;
      p_addr <= '0;
      p_data <= '0;
      p_org  <= 1'b0;
    end else if (launch_i) begin
      cnt    <= (op_i == OP_WRAL) ? CW'(WRAL_CYC) : CW'(BUSY_CYC);
      p_op   <= op_i;
      p_addr <= addr_i;
      p_data <= data_i;
      p_org  <= org16_i;
    end else if (busy_o) begin
      cnt <= cnt - CW'(1);
    end
  end

  // Array update happens at the end of the busy window.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < BYTES; i++) begin
        if (p_op == OP_ERAL)
          mem[i] <= '1;
        else if (p_op == OP_WRAL)
          mem[i] <= (p_org && !i[0]) ? p_data[DW-1:BYTE_W] : p_data[BYTE_W-1:0];
        else if (p_org ? (i[AW-1:1] == p_addr[AW-2:0]) : (i[AW-1:0] == p_addr))
          mem[i] <= (p_op == OP_ERASE) ? '1 :
                    ((p_org && !i[0]) ? p_data[DW-1:BYTE_W] : p_data[BYTE_W-1:0]);
      end
    end
  end

  assign rd_word_o = org16_i ? {mem[{rd_addr_i[AW-2:0], 1'b0}], mem[{rd_addr_i[AW-2:0], 1'b1}]}
                             : {{BYTE_W{1'b0}}, mem[rd_addr_i]};

  a_r9_busy_from_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(launch_i));
  a_r9_no_launch_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !launch_i);
endmodule

// File: rtl/uw_ctrl.sv
module uw_ctrl
  import uw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int NB_W = $clog2(AW + 3 + DW),
  localparam int BC_W = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          org16_i,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_word_i,
  output logic          launch_o,
  output uw_op_e        op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          do_o,
  output logic          do_oe_o
);
  typedef enum logic [1:0] {S_WAIT, S_SHIFT, S_READ, S_FULL} st_e;

  st_e             st;
  logic            cs_q, sclk_q, wen, armed, complete;
  logic [1:0]      opc;
  logic [DW-1:0]   sh;
  logic [NB_W-1:0] nbit;
  logic [BC_W-1:0] bitc;

  logic            sclk_rise, cs_fall;
  logic [DW-1:0]   sh_n;
  logic [NB_W-1:0] n_n, af, dw;
  logic [BC_W-1:0] dwm1;
  logic [1:0]      ext;
  uw_op_e          dec;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign cs_fall   = ~cs_i & cs_q;
  assign sh_n      = {sh[DW-2:0], di_i};
  assign n_n       = nbit + NB_W'(1);
  assign af        = org16_i ? NB_W'(AW) : NB_W'(AW + 1);
  assign dw        = org16_i ? NB_W'(DW) : NB_W'(DW / 2);
  assign dwm1      = org16_i ? BC_W'(DW - 1) : BC_W'(DW / 2 - 1);
  assign ext       = org16_i ? sh_n[AW-1 -: 2] : sh_n[AW -: 2];

  always_comb begin
    unique case (opc)
      2'b10:   dec = OP_READ;
      2'b01:   dec = OP_WRITE;
      2'b11:   dec = OP_ERASE;
      default: begin
        unique case (ext)
          2'b11:   dec = OP_EWEN;
          2'b00:   dec = OP_EWDS;
          2'b10:   dec = OP_ERAL;
          default: dec = OP_WRAL;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_WAIT; cs_q <= 1'b0; sclk_q <= 1'b0; wen <= 1'b0; armed <= 1'b0;
      complete <= 1'b0; opc <= '0; sh <= '0; nbit <= '0; bitc <= '0;
      launch_o <= 1'b0; op_o <= OP_NONE; addr_o <= '0; data_o <= '0;
      rd_addr_o <= '0; do_o <= 1'b0; do_oe_o <= 1'b0;
    end else begin
      cs_q     <= cs_i;
      sclk_q   <= sclk_i;
      launch_o <= 1'b0;
      if (!cs_i) begin
        st <= S_WAIT; nbit <= '0; do_oe_o <= 1'b0; do_o <= 1'b0; complete <= 1'b0;
        if (cs_fall && complete) begin
          unique case (op_o)
            OP_EWEN: wen <= 1'b1;
            OP_EWDS: wen <= 1'b0;
            OP_READ, OP_NONE: ;
            default: if (wen) begin launch_o <= 1'b1; armed <= 1'b1; end
          endcase
        end
      end else begin
        unique case (st)
          S_WAIT: begin
            do_oe_o <= armed;
            do_o    <= ~busy_i;
            if (sclk_rise && di_i) begin
              armed   <= 1'b0;
              do_oe_o <= 1'b0;
              nbit    <= '0;
              st      <= busy_i ? S_FULL : S_SHIFT;
            end
          end
          S_SHIFT: if (sclk_rise) begin
            sh   <= sh_n;
            nbit <= n_n;
            if (n_n == NB_W'(2)) opc <= sh_n[1:0];
            if (n_n == NB_W'(2) + af) begin
              op_o   <= dec;
              addr_o <= org16_i ? {1'b0, sh_n[AW-2:0]} : sh_n[AW-1:0];
              if (dec == OP_READ) begin
                st        <= S_READ;
                rd_addr_o <= org16_i ? {1'b0, sh_n[AW-2:0]} : sh_n[AW-1:0];
                bitc      <= '0;
                do_o      <= 1'b0;
                do_oe_o   <= 1'b1;
              end else if (dec != OP_WRITE && dec != OP_WRAL) begin
                complete <= 1'b1;
                st       <= S_FULL;
              end
            end
            if (n_n == NB_W'(2) + af + dw) begin
              data_o   <= org16_i ? sh_n : {{(DW/2){1'b0}}, sh_n[DW/2-1:0]};
              complete <= 1'b1;
              st       <= S_FULL;
            end
          end
          S_READ: if (sclk_rise) begin
            do_o <= rd_word_i[dwm1 - bitc];
            if (bitc == dwm1) begin
              bitc      <= '0;
              rd_addr_o <= org16_i ? {1'b0, rd_addr_o[AW-2:0] + 1'b1} : rd_addr_o + 1'b1;
            end else begin
              bitc <= bitc + BC_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r8_hiz_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o);
  a_r1_idle_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (st == S_WAIT));
  a_r5_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_READ && $past(st) != S_READ) |-> (do_oe_o && !do_o));
  a_r6_launch_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> wen);
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
  import uw_pkg::*;
#(
  parameter int BYTES       = 256,
  parameter int BYTE_W      = 8,
  parameter int BUSY_CYC    = 200,
  parameter int WRAL_CYC    = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic org16_i,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int AW = $clog2(BYTES);
  localparam int DW = 2 * BYTE_W;

  logic [2:0]    sq;
  logic          launch, busy;
  uw_op_e        op;
  logic [AW-1:0] addr, rd_addr;
  logic [DW-1:0] data, rd_word;

  uw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_i, sclk_i, di_i}), .q_o(sq)
  );

  uw_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .org16_i,
    .cs_i(sq[2]), .sclk_i(sq[1]), .di_i(sq[0]),
    .busy_i(busy), .rd_word_i(rd_word),
    .launch_o(launch), .op_o(op), .addr_o(addr), .data_o(data),
    .rd_addr_o(rd_addr), .do_o, .do_oe_o
  );

  uw_array #(.BYTES(BYTES), .BYTE_W(BYTE_W), .BUSY_CYC(BUSY_CYC), .WRAL_CYC(WRAL_CYC)) u_array (
    .clk_i, .rst_ni, .org16_i,
    .launch_i(launch), .op_i(op), .addr_i(addr), .data_i(data),
    .rd_addr_i(rd_addr), .rd_word_o(rd_word), .busy_o(busy)
  );
endmodule

// File: tb/uw_eeprom_tb.sv
module uw_eeprom_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic org16 = 1'b1, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic do_w, do_oe;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  uw_eeprom u_dut (
    .clk_i(clk), .rst_ni(rst_n), .org16_i(org16), .cs_i(cs), .sclk_i(sclk),
    .di_i(di), .do_o(do_w), .do_oe_o(do_oe)
  );

  typedef struct packed { logic org; logic [7:0] a; logic [15:0] d; } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b1, 8'h05, 16'hA5C3}, '{1'b1, 8'h7F, 16'h0F0F},
    '{1'b0, 8'hC8, 16'h005A}, '{1'b0, 8'h01, 16'h0096}
  };

  function automatic int af(); return org16 ? 8 : 9; endfunction
  function automatic int dw(); return org16 ? 16 : 8; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk) di = b;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic cs_on();  @(negedge clk) cs = 1'b1; repeat (6) @(negedge clk); endtask
  task automatic cs_off(); @(negedge clk) begin cs = 1'b0; di = 1'b0; end repeat (8) @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input int nd);
    cs_on();
    send(3'b101, 3);
    send({24'b0, a}, af());
    for (int i = dw() - 1; i >= dw() - nd; i--) tick(d[i]);
    cs_off();
  endtask

  task automatic ext_cmd(input logic [1:0] e, input logic [15:0] d, input logic has_d);
    cs_on();
    send(3'b100, 3);
    send(32'(e) << (af() - 2), af());
    if (has_d) send({16'b0, d}, dw());
    cs_off();
  endtask

  task automatic wait_ready(input string req);
    cs_on();
    chk({req, " busy status"}, {do_oe, do_w}, 2'b10);
    for (int i = 0; i < 5000 && do_w !== 1'b1; i++) @(negedge clk);
    chk({req, " ready status"}, {do_oe, do_w}, 2'b11);
    cs_off();
  endtask

  task automatic rd(input logic [7:0] a, input int n, input logic [15:0] e0,
                    input logic [15:0] e1, input string req);
    logic [15:0] got;
    cs_on();
    send(3'b110, 3);
    send({24'b0, a}, af());
    chk({req, " dummy zero"}, {do_oe, do_w}, 2'b10);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < dw(); b++) begin
        tick(1'b0);
        got = {got[14:0], do_w};
      end
      chk(req, got, (w == 0) ? e0 : e1);
    end
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 oe at reset", do_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h03, 1, 16'hFFFF, 16'h0, "R10 erased after reset");

    // R6: locked after reset
    wr(8'h03, 16'h1234, 16);
    cs_on(); chk("R6 no status when locked", do_oe, 1'b0); cs_off();
    rd(8'h03, 1, 16'hFFFF, 16'h0, "R6 locked write ignored");

    // R1: idle clocks with DI low, then enable (R2 sub-code 11)
    cs_on();
    send(32'h0, 5);
    send(3'b100, 3); send(32'hC0, 8);
    cs_off();

    // R3: table of organization / address / data vectors
    for (int k = 0; k < 4; k++) begin
      org16 = VECS[k].org;
      wr(VECS[k].a, VECS[k].d, dw());
      wait_ready("R9 write");
      rd(VECS[k].a, 1, VECS[k].d, 16'h0, "R3 write readback");
    end
    org16 = 1'b1;

    // R5: sequential read and wrap (word 0 = {FF, 96} after x8 byte 1 write)
    wr(8'h06, 16'hBEEF, 16); wait_ready("R9 write");
    rd(8'h05, 2, 16'hA5C3, 16'hBEEF, "R5 sequential");
    rd(8'h7F, 2, 16'h0F0F, 16'hFF96, "R5 wrap");

    // R7: erase single word
    cs_on(); send(3'b111, 3); send(32'h05, 8); cs_off();
    wait_ready("R9 erase");
    rd(8'h05, 2, 16'hFFFF, 16'hBEEF, "R7 erase word");

    // R4: truncated write not executed
    wr(8'h06, 16'h0000, 10);
    cs_on(); chk("R4 no launch", do_oe, 1'b0); cs_off();
    rd(8'h06, 1, 16'hBEEF, 16'h0, "R4 truncated write");

    // R9: command started while busy is dropped
    wr(8'h0A, 16'h1111, 16);
    wr(8'h0B, 16'h2222, 16);
    repeat (800) @(negedge clk);
    rd(8'h0A, 2, 16'h1111, 16'hFFFF, "R9 start while busy");

    // R8: status persists until a start bit then select low
    wr(8'h0C, 16'h3333, 16); wait_ready("R9 write");
    cs_on(); chk("R8 status still shown", {do_oe, do_w}, 2'b11);
    tick(1'b1); cs_off();
    cs_on(); chk("R8 status cleared", do_oe, 1'b0); cs_off();

    // R7: write-all then erase-all
    ext_cmd(2'b01, 16'hC33C, 1'b1); wait_ready("R9 write-all");
    rd(8'h00, 1, 16'hC33C, 16'h0, "R7 write-all low");
    rd(8'h40, 1, 16'hC33C, 16'h0, "R7 write-all mid");
    ext_cmd(2'b10, 16'h0, 1'b0); wait_ready("R9 erase-all");
    rd(8'h20, 1, 16'hFFFF, 16'h0, "R7 erase-all");

    // R6: disable locks again; read still works
    ext_cmd(2'b00, 16'h0, 1'b0);
    wr(8'h02, 16'h5555, 16);
    cs_on(); chk("R6 disabled no status", do_oe, 1'b0); cs_off();
    rd(8'h02, 1, 16'hFFFF, 16'h0, "R6 disabled write ignored");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule